// File: doc/BRIEF.md
# 16-to-32-bit Bus Width Bridge

This block is a 16-bit slave that fronts a 32-bit secondary bus on which it is the only master, so it never arbitrates. Software on the 16-bit side reaches one aligned 32-bit location on the far bus with two back-to-back 16-bit accesses. The block pairs them up. A write sequence collects the upper half first. It then performs the whole 32-bit write when the lower half arrives. A read sequence fetches the full 32 bits on its first access, hands back the upper half, and serves the lower half from a holding register on the second access.

The far-bus address is made of two parts. A 12-bit offset register supplies bits 31..20. The slave address latched for the transfer supplies bits 19..2, and bits 1..0 are zero. A single 16-bit write with slave address bit 20 set reloads the offset register. Base-address comparison happens outside the block and arrives on a select input. Far-bus transfers use a one-cycle address strobe, followed by a data strobe that is held until the far side signals completion.

Top module: `wbridge_16to32`

## Requirements
- R1: An access is accepted only while `s_sel` and `s_strobe` are high and `s_am` is one of 0x39, 0x3A, 0x3D or 0x3E. Any other access is never acknowledged and causes no far-bus activity.
- R2: The first write of a pair latches slave address bits 19..2 and the data word as the upper half. It is acknowledged with no far-bus activity.
- R3: The second write of a pair runs one far-bus write. The address is {offset, latched bits 19..2, 2'b00} and the data is {upper half, this write's word}. `m_astb` is high for exactly one cycle, then `m_dstb` stays high with a stable address and data until `m_done`. No acknowledge is given before that.
- R4: The first read of a pair runs one far-bus read at {offset, slave address bits 19..2, 2'b00}. Once `m_done` arrives, it acknowledges with far-bus bits 31..16 on `s_rdata`.
- R5: The second read of a pair returns the far-bus bits 15..0 kept from the first read, with no far-bus activity.
- R6: A write with slave address bit 20 set loads the offset from `s_wdata[15:4]`, which become far-bus address bits 31..20. `s_wdata[3:0]` are ignored. It completes in one access with no far-bus activity.
- R7: The offset register cannot be read back. A read with address bit 20 set is an ordinary first or second read.
- R8: `led_offset` pulses for one cycle after each offset load. `led_xfer` pulses for one cycle after each completed far-bus transfer.
- R9: A pairing flag selects first or second half. It is cleared by reset, by completion of a pair, and by an offset write. An access in the opposite direction to the pending half starts a new pair as a first half.
- R10: `s_ack` is high only while `s_strobe` is high, and falls in the same cycle that `s_strobe` falls.
- R11: After reset, `s_ack`, `m_astb`, `m_dstb`, `led_offset` and `led_xfer` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_sel | input | 1 | Base address match from external decoder |
| s_strobe | input | 1 | Slave data strobe active |
| s_write | input | 1 | Slave access is a write |
| s_am | input | 6 | Slave address modifier |
| s_addr | input | 20 | Slave address bits 20..1 |
| s_wdata | input | 16 | Slave write data |
| s_rdata | output | 16 | Slave read data |
| s_ack | output | 1 | Slave acknowledge |
| m_addr | output | 32 | Far-bus address |
| m_write | output | 1 | Far-bus transfer is a write |
| m_wdata | output | 32 | Far-bus write data |
| m_astb | output | 1 | Far-bus address phase |
| m_dstb | output | 1 | Far-bus data phase |
| m_rdata | input | 32 | Far-bus read data |
| m_done | input | 1 | Far-bus transfer complete |
| led_offset | output | 1 | Offset load indicator pulse |
| led_xfer | output | 1 | Far-bus transfer indicator pulse |

## Verification
On every cycle the assertions check the far-bus handshake. They confirm that the address phase is followed by the data phase, that the address and data stay stable during the data phase, that no acknowledge arrives while a far-bus transfer runs, that the transfer indicator follows a completion, that bad modifiers are refused, and that the acknowledge is released. The bench's sequences are needed for everything that depends on pairing history. That covers which half comes first, the far-bus address and data built from the offset and the latched upper word, the read buffer, and pair restarts after out-of-order or offset accesses. These are compared against a behavioural model of the pairing state.

// File: rtl/wbridge_16to32.sv
module wbridge_16to32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_sel,
  input  logic        s_strobe,
  input  logic        s_write,
  input  logic [5:0]  s_am,
  input  logic [20:1] s_addr,
  input  logic [15:0] s_wdata,
  output logic [15:0] s_rdata,
  output logic        s_ack,
  output logic [31:0] m_addr,
  output logic        m_write,
  output logic [31:0] m_wdata,
  output logic        m_astb,
  output logic        m_dstb,
  input  logic [31:0] m_rdata,
  input  logic        m_done,
  output logic        led_offset,
  output logic        led_xfer
);

  typedef enum logic [1:0] {IDLE, MADDR, MDATA, HOLD} state_t;

  state_t      state;
  logic        half, pend_wr;
  logic [11:0] offset;
  logic [19:2] lat_addr;
  logic [15:0] hi_q, lo_q, rd_q;

  logic am_ok, start, off_wr, second;

  assign am_ok  = (s_am == 6'h39) || (s_am == 6'h3A) || (s_am == 6'h3D) || (s_am == 6'h3E);
  assign start  = (state == IDLE) && s_sel && s_strobe && am_ok;
  assign off_wr = s_write && s_addr[20];
  assign second = half && (pend_wr == s_write);

  assign s_ack   = (state == HOLD) && s_strobe;
  assign s_rdata = rd_q;
  assign m_astb  = (state == MADDR);
  assign m_dstb  = (state == MDATA);
  assign m_wdata = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      half       <= 1'b0;
      pend_wr    <= 1'b0;
      offset     <= '0;
      lat_addr   <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      rd_q       <= '0;
      m_addr     <= '0;
      m_write    <= 1'b0;
      led_offset <= 1'b0;
      led_xfer   <= 1'b0;
    end else begin
      led_offset <= 1'b0;
      led_xfer   <= 1'b0;
      case (state)
        IDLE: if (start) begin
          if (off_wr) begin
            offset     <= s_wdata[15:4];
            half       <= 1'b0;
            led_offset <= 1'b1;
            state      <= HOLD;
          end else if (s_write) begin
            if (second) begin
              lo_q    <= s_wdata;
              half    <= 1'b0;
              m_addr  <= {offset, lat_addr, 2'b00};
              m_write <= 1'b1;
              state   <= MADDR;
            end else begin
              lat_addr <= s_addr[19:2];
              hi_q     <= s_wdata;
              half     <= 1'b1;
              pend_wr  <= 1'b1;
              state    <= HOLD;
            end
          end else begin
            if (second) begin
              rd_q  <= lo_q;
              half  <= 1'b0;
              state <= HOLD;
            end else begin
              m_addr  <= {offset, s_addr[19:2], 2'b00};
              m_write <= 1'b0;
              half    <= 1'b1;
              pend_wr <= 1'b0;
              state   <= MADDR;
            end
          end
        end
        MADDR: state <= MDATA;
        MDATA: if (m_done) begin
          if (!m_write) begin
            rd_q <= m_rdata[31:16];
            lo_q <= m_rdata[15:0];
          end
          led_xfer <= 1'b1;
          state    <= HOLD;
        end
        HOLD: if (!s_strobe) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    m_astb |=> m_dstb && !m_astb); // R3
  AST_NO_ACK_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (m_astb || m_dstb) |-> !s_ack); // R3
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_dstb && $past(m_dstb)) |-> ($stable(m_addr) && $stable(m_wdata) && $stable(m_write))); // R3
  AST_XFER_LED: assert property (@(posedge clk) disable iff (!rst_n)
    led_xfer |-> $past(m_dstb && m_done)); // R8
  AST_BAD_AM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE && s_strobe && !am_ok) |=> !s_ack && !m_astb); // R1
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HOLD && !s_strobe) |=> (state == IDLE)); // R10
  AST_OFFSET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    led_offset |-> !m_astb && !m_dstb); // R6

endmodule

// File: tb/test_wbridge_16to32.sv
module test_wbridge_16to32;
  logic clk = 0, rst_n = 0;
  logic s_sel = 0, s_strobe = 0, s_write = 0;
  logic [5:0] s_am = 6'h39;
  logic [20:1] s_addr = '0;
  logic [15:0] s_wdata = '0, s_rdata;
  logic s_ack, m_write, m_astb, m_dstb, led_offset, led_xfer;
  logic [31:0] m_addr, m_wdata;
  logic [31:0] m_rdata = '0;
  logic m_done = 0;

  always #5 clk = ~clk;

  wbridge_16to32 i_wbridge_16to32 (.*);

  int checks = 0, errors = 0;
  int off_pulses = 0, x_pulses = 0, astb_cnt = 0;
  logic [64:0] mq[$];

  logic [11:0] e_off = 0;
  logic e_half = 0, e_pw = 0;
  logic [19:2] e_lat = 0;
  logic [15:0] e_hi = 0, e_lo = 0;
  int e_txn = 0, e_offp = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, a[31:16] ^ 16'h1234};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (led_offset) off_pulses++;
    if (led_xfer) x_pulses++;
    if (m_astb) astb_cnt++;
  end

  initial begin : responder
    int cnt = 0;
    forever begin
      @(negedge clk);
      m_done = 0;
      if (m_dstb) begin
        m_rdata = pat(m_addr);
        if (cnt == 2) begin
          m_done = 1;
          mq.push_back({m_write, m_addr, m_wdata});
          cnt = 0;
        end else cnt++;
      end
    end
  end

  task automatic scyc(input logic wr, input logic [20:1] a, input logic [15:0] d,
                      input logic [5:0] am, input logic sel,
                      output logic acked, output logic [15:0] rd);
    @(negedge clk);
    s_write = wr; s_addr = a; s_wdata = d; s_am = am; s_sel = sel; s_strobe = 1;
    acked = 0;
    for (int i = 0; i < 30 && !acked; i++) begin
      @(posedge clk); #1;
      if (s_ack) acked = 1;
    end
    rd = s_rdata;
    @(negedge clk);
    s_strobe = 0; s_sel = 0;
    #1 chk(s_ack == 0, "R10 ack follows strobe", s_ack, 0);
    @(posedge clk); #1;
    chk(s_ack == 0, "R10 ack released", s_ack, 0);
  endtask

  task automatic acc(input logic wr, input logic [20:1] a, input logic [15:0] d, input string tag);
    logic acked;
    logic [15:0] rd;
    logic [64:0] t;
    logic [31:0] ea, v;
    int q0 = mq.size();
    scyc(wr, a, d, 6'h3D, 1'b1, acked, rd);
    chk(acked, {tag, " ack"}, acked, 1);
    if (wr && a[20]) begin
      e_off = d[15:4]; e_half = 0; e_offp++;
      chk(mq.size() == q0, {tag, " R6 no far-bus txn"}, mq.size(), q0);
      chk(off_pulses == e_offp, {tag, " R8 offset pulse"}, off_pulses, e_offp);
    end else if (e_half && e_pw == wr) begin
      e_half = 0;
      if (wr) begin
        ea = {e_off, e_lat, 2'b00};
        e_txn++;
        chk(mq.size() == q0 + 1, {tag, " R3 one write txn"}, mq.size(), q0 + 1);
        if (mq.size() > q0) begin
          t = mq.pop_back();
          chk(t == {1'b1, ea, e_hi, d}, {tag, " R3 write txn"}, t, {1'b1, ea, e_hi, d});
        end
      end else begin
        chk(mq.size() == q0, {tag, " R5 no far-bus txn"}, mq.size(), q0);
        chk(rd == e_lo, {tag, " R5 low word"}, rd, e_lo);
      end
    end else begin
      e_half = 1; e_pw = wr;
      if (wr) begin
        e_lat = a[19:2]; e_hi = d;
        chk(mq.size() == q0, {tag, " R2 no far-bus txn"}, mq.size(), q0);
      end else begin
        ea = {e_off, a[19:2], 2'b00};
        v = pat(ea);
        e_lo = v[15:0];
        e_txn++;
        chk(mq.size() == q0 + 1, {tag, " R4 one read txn"}, mq.size(), q0 + 1);
        if (mq.size() > q0) begin
          t = mq.pop_back();
          chk(t[64:32] == {1'b0, ea}, {tag, " R4 read addr"}, t[64:32], {1'b0, ea});
        end
        chk(rd == v[31:16], {tag, " R4 high word"}, rd, v[31:16]);
      end
    end
    chk(x_pulses == e_txn, {tag, " R8 xfer pulses"}, x_pulses, e_txn);
    chk(astb_cnt == e_txn, {tag, " R3 one address phase per txn"}, astb_cnt, e_txn);
  endtask

  task automatic refused(input logic wr, input logic [5:0] am, input logic sel, input string tag);
    logic acked;
    logic [15:0] rd;
    int q0 = mq.size();
    scyc(wr, 20'h00040, 16'h1111, am, sel, acked, rd);
    chk(!acked, {tag, " R1 no ack"}, acked, 0);
    chk(mq.size() == q0, {tag, " R1 no txn"}, mq.size(), q0);
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({s_ack, m_astb, m_dstb, led_offset, led_xfer} == 0, "R11 reset outputs",
        {s_ack, m_astb, m_dstb, led_offset, led_xfer}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk({s_ack, m_astb, m_dstb} == 0, "R11 idle after reset", {s_ack, m_astb, m_dstb}, 0);

    acc(1, 20'h80000 | 20'h00001, 16'hABCF, "R6 offset load");
    acc(1, 20'h091A2, 16'hDEAD, "R2 first write");
    acc(1, 20'h00777, 16'hBEEF, "R3 second write");
    acc(0, 20'h04567, 16'h0, "R4 first read");
    acc(0, 20'h00000, 16'h0, "R5 second read");

    refused(0, 6'h09, 1'b1, "R1 bad modifier");
    refused(1, 6'h2D, 1'b1, "R1 bad modifier write");
    refused(0, 6'h3A, 1'b0, "R1 not selected");
    acc(1, 20'h01230, 16'h1357, "R1 valid after refusal");
    acc(1, 20'h01232, 16'h2468, "R1 pair completes");

    acc(1, 20'h02000, 16'h1111, "R9 write half");
    acc(0, 20'h03004, 16'h0, "R9 read restarts pair");
    acc(0, 20'h03006, 16'h0, "R9 read second");
    acc(1, 20'h04008, 16'h2222, "R9 fresh first write");
    acc(1, 20'h0400A, 16'h3333, "R9 fresh second write");

    acc(1, 20'h05000, 16'h4444, "R9 write half before offset");
    acc(1, 20'h80000, 16'h123F, "R9 offset clears pair");
    acc(1, 20'h06010, 16'h5555, "R9 first after offset");
    acc(1, 20'h06012, 16'h6666, "R9 second after offset");

    acc(0, 20'h80010, 16'h0, "R7 read with bit20 is ordinary read");
    acc(0, 20'h80012, 16'h0, "R7 second read");
    acc(1, 20'h0000C, 16'h0F0F, "R3 write mid offset");
    acc(1, 20'h0000E, 16'hF0F0, "R3 write second mid offset");

    repeat (5) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule